// File: doc/BRIEF.md
# Multicycle Full-Product Multiplier with Serial Write-Back

This block multiplies two 32-bit operands and returns the complete 64-bit product, in either unsigned or two's-complement signed form. One unsigned shift-add engine serves both modes. For a signed request, a single fix-up step subtracts the sign-selected operands from the upper half of the unsigned result. The lower half is never altered.

The result leaves through one register-file write port, one word per cycle. The lower word goes out first, to its own destination index. The upper word follows in the next cycle, to a second index. A pipeline pulses the start request with both operands, the mode and the two indices. It then stalls while the busy flag is high. Requests made while the unit is busy are dropped.

Top module: `mul_fp_unit`

## Requirements
- R1: With signed_i=0, the two written words concatenate as {upper, lower} to the unsigned 64-bit product of a_i and b_i.
- R2: With signed_i=1, the two written words concatenate as {upper, lower} to the two's-complement 64-bit product of a_i and b_i. This holds for the most negative operand as well.
- R3: A request is accepted on a clock edge where start_i=1 and busy_o=0. The lower word appears with wr_en_o=1 and wr_idx_o=dst_lo_i in the 34th cycle after the accepting edge. The upper word follows in the next cycle with wr_idx_o=dst_hi_i.
- R4: wr_en_o is high for exactly two consecutive cycles per accepted request and low at all other times.
- R5: busy_o goes high in the cycle after the accepting edge. It stays high through the cycle of the upper-word write and is low in the cycle after it.
- R6: A start_i pulse while busy_o=1 is ignored. The result, the indices and the timing of the running operation are unchanged.
- R7: When dst_lo_i equals dst_hi_i, both writes target that index and the upper word is the later write.
- R8: While rst_ni is low, busy_o and wr_en_o are 0.
- R9: A start_i held high is accepted on the first edge after busy_o returns low, so operations run back to back with one idle cycle between them.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Clock |
| rst_ni | input | 1 | Asynchronous reset, active low |
| start_i | input | 1 | Request; taken when busy_o is low |
| signed_i | input | 1 | 1 = two's-complement operands, 0 = unsigned |
| a_i | input | 32 | First operand |
| b_i | input | 32 | Second operand |
| dst_lo_i | input | 5 | Destination index for the lower word |
| dst_hi_i | input | 5 | Destination index for the upper word |
| busy_o | output | 1 | Operation in progress |
| wr_en_o | output | 1 | Register write enable |
| wr_idx_o | output | 5 | Register write index |
| wr_data_o | output | 32 | Register write data |

## Verification
The assertions assume that start_i is only acted on when busy_o is low. They capture the destination indices only at such an edge and expect those indices to come back unchanged at write-back. They also assume that reset is not applied in the middle of an operation. The stimulus respects this: reset is asserted only once, at the start. Extra requests issued during busy carry different operands and indices, so that a design which took them would produce visibly wrong writes.

// File: rtl/mul_fp_pkg.sv
package mul_fp_pkg;
  typedef enum logic [2:0] {
    ST_IDLE,
    ST_RUN,
    ST_FIX,
    ST_WLO,
    ST_WHI
  } mul_st_e;
endpackage

// File: rtl/mul_fp_ctrl.sv
module mul_fp_ctrl
  import mul_fp_pkg::*;
#(
  parameter int W = 32
) (
  input  logic    clk_i,
  input  logic    rst_ni,
  input  logic    start_i,
  output mul_st_e state_o,
  output logic    accept_o,
  output logic    step_o,
  output logic    fix_o
);
  localparam int CW = (W > 1) ? $clog2(W) : 1;

  mul_st_e       st_q;
  logic [CW-1:0] cnt_q;

  assign accept_o = start_i && (st_q == ST_IDLE);
  assign step_o   = (st_q == ST_RUN);
  assign fix_o    = (st_q == ST_FIX);
  assign state_o  = st_q;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      st_q  <= ST_IDLE;
      cnt_q <= '0;
    end else begin
      unique case (st_q)
        ST_IDLE: if (start_i) begin
          st_q  <= ST_RUN;
          cnt_q <= '0;
        end
        ST_RUN: begin
          cnt_q <= cnt_q + 1'b1;
          if (cnt_q == CW'(W - 1)) st_q <= ST_FIX;
        end
        ST_FIX:  st_q <= ST_WLO;
        ST_WLO:  st_q <= ST_WHI;
        ST_WHI:  st_q <= ST_IDLE;
        default: st_q <= ST_IDLE;
      endcase
    end
  end
endmodule

// File: rtl/mul_fp_core.sv
module mul_fp_core #(
  parameter int W = 32
) (
  input  logic         clk_i,
  input  logic         rst_ni,
  input  logic         load_i,
  input  logic         step_i,
  input  logic         fix_i,
  input  logic [W-1:0] a_i,
  input  logic [W-1:0] b_i,
  input  logic [W-1:0] corr_i,
  output logic [W-1:0] hi_o,
  output logic [W-1:0] lo_o
);
  logic [W-1:0] hi_q, lo_q;
  logic [W:0]   sum;

  // multiplier bits sit in lo_q and are consumed from bit 0
  assign sum = {1'b0, hi_q} + (lo_q[0] ? {1'b0, b_i} : '0);

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      hi_q <= '0;
      lo_q <= '0;
    end else if (load_i) begin
      hi_q <= '0;
      lo_q <= a_i;
    end else if (step_i) begin
      hi_q <= sum[W:1];
      lo_q <= {sum[0], lo_q[W-1:1]};
    end else if (fix_i) begin
      hi_q <= hi_q - corr_i;
    end
  end

  assign hi_o = hi_q;
  assign lo_o = lo_q;
endmodule

// File: rtl/mul_fp_sign_corr.sv
module mul_fp_sign_corr #(
  parameter int W = 32
) (
  input  logic         signed_i,
  input  logic [W-1:0] a_i,
  input  logic [W-1:0] b_i,
  output logic [W-1:0] corr_o
);
  logic [W-1:0] sel_b, sel_a;
  // selections, not products: a negative operand pulls in the other one
  assign sel_b  = (signed_i && a_i[W-1]) ? b_i : '0;
  assign sel_a  = (signed_i && b_i[W-1]) ? a_i : '0;
  assign corr_o = sel_b + sel_a;
endmodule

// File: rtl/mul_fp_unit.sv
module mul_fp_unit
  import mul_fp_pkg::*;
#(
  parameter int W  = 32,
  parameter int IW = 5
) (
  input  logic          clk_i,
  input  logic          rst_ni,
  input  logic          start_i,
  input  logic          signed_i,
  input  logic [W-1:0]  a_i,
  input  logic [W-1:0]  b_i,
  input  logic [IW-1:0] dst_lo_i,
  input  logic [IW-1:0] dst_hi_i,
  output logic          busy_o,
  output logic          wr_en_o,
  output logic [IW-1:0] wr_idx_o,
  output logic [W-1:0]  wr_data_o
);
  mul_st_e       st;
  logic          accept, step, fix;
  logic [W-1:0]  a_q, b_q, corr, hi, lo;
  logic          sgn_q;
  logic [IW-1:0] dlo_q, dhi_q;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      a_q   <= '0;
      b_q   <= '0;
      sgn_q <= 1'b0;
      dlo_q <= '0;
      dhi_q <= '0;
    end else if (accept) begin
      a_q   <= a_i;
      b_q   <= b_i;
      sgn_q <= signed_i;
      dlo_q <= dst_lo_i;
      dhi_q <= dst_hi_i;
    end
  end

  mul_fp_ctrl #(.W(W)) u_ctrl (
    .clk_i   (clk_i),
    .rst_ni  (rst_ni),
    .start_i (start_i),
    .state_o (st),
    .accept_o(accept),
    .step_o  (step),
    .fix_o   (fix)
  );

  mul_fp_core #(.W(W)) u_core (
    .clk_i  (clk_i),
    .rst_ni (rst_ni),
    .load_i (accept),
    .step_i (step),
    .fix_i  (fix),
    .a_i    (a_i),
    .b_i    (b_q),
    .corr_i (corr),
    .hi_o   (hi),
    .lo_o   (lo)
  );

  mul_fp_sign_corr #(.W(W)) u_corr (
    .signed_i(sgn_q),
    .a_i     (a_q),
    .b_i     (b_q),
    .corr_o  (corr)
  );

  assign busy_o    = (st != ST_IDLE);
  assign wr_en_o   = (st == ST_WLO) || (st == ST_WHI);
  assign wr_idx_o  = (st == ST_WHI) ? dhi_q : dlo_q;
  assign wr_data_o = (st == ST_WHI) ? hi : lo;
endmodule

// File: rtl/mul_fp_unit_chk.sv
module mul_fp_unit_chk #(
  parameter int IW = 5
) (
  input logic          clk_i,
  input logic          rst_ni,
  input logic          start_i,
  input logic [IW-1:0] dst_lo_i,
  input logic [IW-1:0] dst_hi_i,
  input logic          busy_o,
  input logic          wr_en_o,
  input logic [IW-1:0] wr_idx_o
);
  logic [IW-1:0] lo_idx_q, hi_idx_q;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      lo_idx_q <= '0;
      hi_idx_q <= '0;
    end else if (start_i && !busy_o) begin
      lo_idx_q <= dst_lo_i;
      hi_idx_q <= dst_hi_i;
    end
  end

  a_r5_busy_rise: assert property (@(posedge clk_i) disable iff (!rst_ni)
    start_i && !busy_o |=> busy_o);
  a_r5_wr_in_busy: assert property (@(posedge clk_i) disable iff (!rst_ni)
    wr_en_o |-> busy_o);
  a_r5_busy_fall: assert property (@(posedge clk_i) disable iff (!rst_ni)
    $fell(busy_o) |-> $past(wr_en_o));
  a_r4_wr_pair: assert property (@(posedge clk_i) disable iff (!rst_ni)
    $rose(wr_en_o) |=> wr_en_o);
  a_r4_wr_end: assert property (@(posedge clk_i) disable iff (!rst_ni)
    wr_en_o && $past(wr_en_o) |=> !wr_en_o);
  a_r3_lo_idx: assert property (@(posedge clk_i) disable iff (!rst_ni)
    $rose(wr_en_o) |-> wr_idx_o == lo_idx_q);
  a_r3_hi_idx: assert property (@(posedge clk_i) disable iff (!rst_ni)
    wr_en_o && $past(wr_en_o) |-> wr_idx_o == hi_idx_q);
  a_r6_no_restart: assert property (@(posedge clk_i) disable iff (!rst_ni)
    busy_o && !wr_en_o |=> busy_o);
endmodule

bind mul_fp_unit mul_fp_unit_chk #(.IW(IW)) u_chk (
  .clk_i   (clk_i),
  .rst_ni  (rst_ni),
  .start_i (start_i),
  .dst_lo_i(dst_lo_i),
  .dst_hi_i(dst_hi_i),
  .busy_o  (busy_o),
  .wr_en_o (wr_en_o),
  .wr_idx_o(wr_idx_o)
);

// File: tb/mul_fp_unit_tb.sv
`timescale 1ns/1ps
module mul_fp_unit_tb;
  logic        clk = 0, rst_n = 0;
  logic        start = 0, sgn = 0;
  logic [31:0] a = 0, b = 0;
  logic [4:0]  dlo = 0, dhi = 0;
  logic        busy, wr_en;
  logic [4:0]  wr_idx;
  logic [31:0] wr_data;

  int errs = 0, checks = 0;
  bit done = 0;

  always #2 clk = ~clk;

  mul_fp_unit u_dut (
    .clk_i(clk), .rst_ni(rst_n), .start_i(start), .signed_i(sgn),
    .a_i(a), .b_i(b), .dst_lo_i(dlo), .dst_hi_i(dhi),
    .busy_o(busy), .wr_en_o(wr_en), .wr_idx_o(wr_idx), .wr_data_o(wr_data)
  );

  // reference: cycles since accept, 0 = idle
  int          m_cnt = 0;
  logic [63:0] m_prod;
  logic [4:0]  m_lo, m_hi;
  bit          m_sgn, m_noise, m_b2b, m_ended;

  always @(posedge clk) begin
    if (!rst_n) begin
      m_cnt = 0; m_ended = 0;
    end else if (m_cnt != 0) begin
      if (start) m_noise = 1;
      m_cnt++;
      if (m_cnt == 36) begin m_cnt = 0; m_ended = 1; end
    end else begin
      if (start) begin
        logic signed [63:0] sa, sb;
        sa = {{32{a[31]}}, a};
        sb = {{32{b[31]}}, b};
        m_prod  = sgn ? 64'(sa * sb) : {32'b0, a} * {32'b0, b};
        m_lo = dlo; m_hi = dhi; m_sgn = sgn;
        m_noise = 0; m_b2b = m_ended; m_cnt = 1;
      end
      m_ended = 0;
    end
  end

  task automatic chk(input bit ok, input string req, input logic [63:0] act, input logic [63:0] exp);
    checks++;
    if (!ok) begin
      errs++;
      $display("FAIL %s: actual=%h expected=%h at %0t", req, act, exp, $time);
    end
  endtask

  always @(negedge clk) begin
    if (!rst_n) begin
      chk(!busy && !wr_en, "R8", {busy, wr_en}, 0);
    end else begin
      bit e_wr;
      string t;
      e_wr = (m_cnt == 34) || (m_cnt == 35);
      chk(busy == (m_cnt != 0), m_b2b ? "R9" : "R5", busy, m_cnt != 0);
      chk(wr_en == e_wr, "R4", wr_en, e_wr);
      if (e_wr && wr_en) begin
        t = (m_lo == m_hi) ? "R7" : "R3";
        chk(wr_idx == ((m_cnt == 34) ? m_lo : m_hi), t, wr_idx, (m_cnt == 34) ? m_lo : m_hi);
        t = m_noise ? "R6" : (m_sgn ? "R2" : "R1");
        chk(wr_data == ((m_cnt == 34) ? m_prod[31:0] : m_prod[63:32]), t, wr_data,
            (m_cnt == 34) ? m_prod[31:0] : m_prod[63:32]);
      end
    end
  end

  task automatic op(input logic [31:0] x, input logic [31:0] y, input bit s,
                    input logic [4:0] lo, input logic [4:0] hi, input bit noise);
    @(negedge clk);
    a = x; b = y; sgn = s; dlo = lo; dhi = hi; start = 1;
    @(negedge clk);
    start = 0;
    if (noise) begin
      repeat (5) @(negedge clk);
      a = ~x; b = x ^ y; sgn = ~s; dlo = lo + 5'd3; dhi = hi + 5'd7; start = 1;
      @(negedge clk);
      start = 0;
      repeat (20) @(negedge clk);
      start = 1;   // also during a write cycle
      while (m_cnt != 35) @(negedge clk);
      start = 0;
    end
    while (m_cnt != 0) @(negedge clk);
  endtask

  initial begin
    repeat (3) @(negedge clk);
    rst_n = 1;
    op(32'd7, 32'd9, 0, 5'd1, 5'd2, 0);                     // R1
    op(32'hFFFF_FFFF, 32'hFFFF_FFFF, 0, 5'd3, 5'd4, 0);     // R1 max
    op(32'hFFFF_FFFF, 32'hFFFF_FFFF, 1, 5'd5, 5'd6, 0);     // R2 -1*-1
    op(32'h8000_0000, 32'h8000_0000, 1, 5'd7, 5'd8, 0);     // R2 min*min
    op(32'h8000_0000, 32'd1, 1, 5'd9, 5'd10, 0);            // R2
    op(32'hFFFF_FFF9, 32'd123456, 1, 5'd11, 5'd12, 0);      // R2 mixed sign
    op(32'd0, 32'hDEAD_BEEF, 1, 5'd13, 5'd14, 0);
    op(32'h1234_5678, 32'h9ABC_DEF0, 0, 5'd15, 5'd15, 0);   // R7
    op(32'h8765_4321, 32'hCAFE_F00D, 1, 5'd20, 5'd21, 1);   // R6
    for (int i = 0; i < 12; i++)
      op(32'h9E37_79B9 * (i + 1), 32'h7F4A_7C15 ^ (i * 32'h0101_0101),
         i[0], 5'(i), 5'(31 - i), 0);
    // R9: start held high over two requests
    @(negedge clk);
    a = 32'hF000_000F; b = 32'h0000_FFFF; sgn = 1; dlo = 5'd22; dhi = 5'd23; start = 1;
    while (m_cnt != 35) @(negedge clk);
    a = 32'h7FFF_FFFF; b = 32'h8000_0001; sgn = 1; dlo = 5'd24; dhi = 5'd25;
    while (m_cnt != 1) @(negedge clk);
    start = 0;
    while (m_cnt != 0) @(negedge clk);
    repeat (3) @(negedge clk);
    done = 1;
    $display("Result: errors=%0d of %0d checks", errs, checks);
    $finish;
  end

  initial begin
    repeat (100000) @(posedge clk);
    if (!done) begin
      errs++; checks++;
      $display("FAIL watchdog: actual=running expected=finished");
      $display("Result: errors=%0d of %0d checks", errs, checks);
      $finish;
    end
  end
endmodule